// File: doc/BRIEF.md
# Slow-Path Predicting Execute Stall Controller

This block sits between an instruction queue and an execute stage built from two units: a short integer unit that takes one cycle, and a floating-point unit that normally takes `FP_CYC` cycles. Each instruction is classified before it executes. The class comes from a small table that is indexed by opcode and written through a simple port. The class says which unit the instruction uses and whether its timing path is predicted to be longer than the normal budget.

A predicted-slow instruction gets exactly one extra cycle. The controller drops the execute clock-enable for one cycle and holds fetch for that time. A slow integer operation therefore takes two cycles, with the first one gated, so it runs at half rate. A slow floating-point operation takes `FP_CYC + 1` cycles, and the gated cycle falls just before its final cycle.

A new instruction is accepted only when the one in execute has at most one cycle left. Results therefore never overlap, and write-back leaves in issue order. The arithmetic is not modelled: each unit is represented only by its cycle count.

Top module: `cp_stall_ctrl`

## Requirements
- R1: After a synchronous reset, `wb_valid` and `fetch_stall` are 0 and `ex_en` is 1. Every table entry holds class 0 (fast integer).
- R2: When `cfg_we` is 1 at a clock edge, the entry at `cfg_addr` takes `cfg_class`. The encoding is: 0 fast integer, 1 slow integer, 2 fast floating-point, 3 slow floating-point (bit 1 selects the floating-point unit, bit 0 marks a slow path). An issue at the same edge reads the old entry.
- R3: An instruction of class 0 accepted at edge k asserts `wb_valid` during the cycle that follows edge k, and never lowers `ex_en`.
- R4: An instruction of class 1 takes two cycles. `ex_en` is 0 in the first cycle, and `wb_valid` is 1 in the second.
- R5: An instruction of class 2 takes `FP_CYC` cycles, with `ex_en` held at 1 throughout.
- R6: An instruction of class 3 takes `FP_CYC + 1` cycles. `ex_en` is 0 only in its second-to-last cycle.
- R7: `fetch_stall` is 1 while the executing instruction has more than one cycle left. An instruction presented while `fetch_stall` is 1 is not accepted and has no effect.
- R8: `wb_valid` pulses exactly once for each accepted instruction. `wb_opcode` carries that instruction's opcode, and results leave in acceptance order.
- R9: For a stream presented back to back, the total time from the first acceptance to the last write-back equals the sum of the per-instruction cycle counts.
- R10: `ex_en` is never 0 in two consecutive cycles. Each instruction extends by one cycle at most.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Class table write enable |
| cfg_addr | input | OPC_W | Opcode whose class is written |
| cfg_class | input | 2 | Class code to store |
| issue_valid | input | 1 | Instruction offered from the queue |
| issue_opcode | input | OPC_W | Opcode of the offered instruction |
| ex_en | output | 1 | Execute stage clock enable, 0 on a stretched cycle |
| fetch_stall | output | 1 | Holds the queue; offered instruction not taken |
| wb_valid | output | 1 | Final execute cycle of an instruction |
| wb_opcode | output | OPC_W | Opcode of the completing instruction |

## Verification
Each of the four classes is issued in isolation. This separates the one-cycle, two-cycle, `FP_CYC` and `FP_CYC + 1` timings, and shows where the single gated cycle falls. A mixed back-to-back stream follows. While stalled, that stream presents a junk opcode whose class would lengthen execution, so an accepted stall-time issue would show up both in the total cycle count and in the write-back order. Rewriting an entry after use, and running on the reset contents of the table, separate a working write port from a fixed decode.

// File: rtl/stallctl_pkg.sv
package stallctl_pkg;

    typedef enum logic [1:0] {
        CLS_INT_FAST = 2'd0,
        CLS_INT_SLOW = 2'd1,
        CLS_FP_FAST  = 2'd2,
        CLS_FP_SLOW  = 2'd3
    } op_class_e;

    typedef struct packed {
        logic fp;
        logic slow;
    } pred_t;

    function automatic pred_t split_class(op_class_e c);
        pred_t p;
        p.fp   = c[1];
        p.slow = c[0];
        return p;
    endfunction

    function automatic int unsigned op_cycles(pred_t p, int unsigned fp_base);
        int unsigned base;
        base = p.fp ? fp_base : 1;
        return base + (p.slow ? 1 : 0);
    endfunction

endpackage

// File: rtl/opclass_table.sv
module opclass_table
    import stallctl_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OPC_W-1:0] wr_addr,
    input  op_class_e        wr_cls,
    input  logic [OPC_W-1:0] rd_addr,
    output op_class_e        rd_cls
);
    localparam int DEPTH = 1 << OPC_W;

    op_class_e mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CLS_INT_FAST;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_cls;
        end
    end

    assign rd_cls = mem[rd_addr];

    // R2: a write lands in the addressed entry
    p_tbl_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_cls));

endmodule

// File: rtl/path_predictor.sv
module path_predictor
    import stallctl_pkg::*;
#(
    parameter int FP_CYC = 3,
    parameter int CW     = 3
) (
    input  op_class_e        cls,
    output logic [CW-1:0]    lat,
    output logic             slow
);
    pred_t p;

    always_comb begin
        p    = split_class(cls);
        lat  = CW'(op_cycles(p, FP_CYC));
        slow = p.slow;
    end

endmodule

// File: rtl/exec_tracker.sv
module exec_tracker #(
    parameter int OPC_W = 4,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CW-1:0]    start_lat,
    input  logic             start_slow,
    input  logic [OPC_W-1:0] start_opc,
    output logic             ex_en,
    output logic             fetch_stall,
    output logic             wb_valid,
    output logic [OPC_W-1:0] wb_opc
);
    typedef struct packed {
        logic             busy;
        logic             slow;
        logic [CW-1:0]    rem;
        logic [OPC_W-1:0] opc;
    } slot_t;

    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    slot_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (start) begin
            cur.busy <= 1'b1;
            cur.slow <= start_slow;
            cur.rem  <= start_lat;
            cur.opc  <= start_opc;
        end else if (cur.busy) begin
            if (cur.rem == ONE) cur.busy <= 1'b0;
            else                cur.rem  <= cur.rem - ONE;
        end
    end

    always_comb begin
        wb_valid    = cur.busy && (cur.rem == ONE);
        fetch_stall = cur.busy && (cur.rem > ONE);
        ex_en       = !(cur.busy && cur.slow && (cur.rem == TWO));
        wb_opc      = cur.opc;
    end

    // R10: the enable never drops for two cycles in a row
    p_gate_single_r10: assert property (@(posedge clk) disable iff (rst)
        !ex_en |=> ex_en);

    // R6: the gated cycle is always followed by the final cycle
    p_gate_then_wb_r6: assert property (@(posedge clk) disable iff (rst)
        !ex_en |=> wb_valid);

    // R7: the last cycle frees the queue
    p_wb_frees_r7: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !fetch_stall);

endmodule

// File: rtl/cp_stall_ctrl.sv
module cp_stall_ctrl
    import stallctl_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int FP_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [OPC_W-1:0] cfg_addr,
    input  logic [1:0]       cfg_class,
    input  logic             issue_valid,
    input  logic [OPC_W-1:0] issue_opcode,
    output logic             ex_en,
    output logic             fetch_stall,
    output logic             wb_valid,
    output logic [OPC_W-1:0] wb_opcode
);
    localparam int CW = $clog2(FP_CYC + 2);

    op_class_e       rd_cls;
    logic [CW-1:0]   lat;
    logic            slow;
    logic            accept;

    opclass_table #(.OPC_W(OPC_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_cls  (op_class_e'(cfg_class)),
        .rd_addr (issue_opcode),
        .rd_cls  (rd_cls)
    );

    path_predictor #(.FP_CYC(FP_CYC), .CW(CW)) u_pred (
        .cls  (rd_cls),
        .lat  (lat),
        .slow (slow)
    );

    assign accept = issue_valid && !fetch_stall;

    exec_tracker #(.OPC_W(OPC_W), .CW(CW)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_lat   (lat),
        .start_slow  (slow),
        .start_opc   (issue_opcode),
        .ex_en       (ex_en),
        .fetch_stall (fetch_stall),
        .wb_valid    (wb_valid),
        .wb_opc      (wb_opcode)
    );

    // R8: an accepted instruction is in execute in the next cycle
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> (wb_valid || fetch_stall));

endmodule

// File: tb/cp_stall_ctrl_tb_top.sv
module cp_stall_ctrl_tb_top;
    localparam int OW  = 4;
    localparam int FPN = 3;
    localparam int JUNK = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [OW-1:0] cfg_addr = '0;
    logic [1:0] cfg_class = '0;
    logic issue_valid = 1'b0;
    logic [OW-1:0] issue_opcode = '0;
    logic ex_en, fetch_stall, wb_valid;
    logic [OW-1:0] wb_opcode;

    always #10 clk = ~clk;

    cp_stall_ctrl #(.OPC_W(OW), .FP_CYC(FPN)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_class(cfg_class), .issue_valid(issue_valid),
        .issue_opcode(issue_opcode), .ex_en(ex_en),
        .fetch_stall(fetch_stall), .wb_valid(wb_valid), .wb_opcode(wb_opcode)
    );

    int checks = 0, fails = 0, cyc = 0;
    int tbl [16];
    int m_busy = 0, m_rem = 0, m_slow = 0;
    int q [$];
    int wb_seen = 0, last_wb_cyc = 0, gate_cnt = 0;
    bit done = 0;

    function automatic int lat_of(int c);
        case (c)
            0: return 1;
            1: return 2;
            2: return FPN;
            default: return FPN + 1;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, advanced on every edge
    always @(posedge clk) begin
        bit acc;
        int c;
        cyc++;
        if (rst) begin
            m_busy = 0; m_rem = 0; m_slow = 0;
            for (int i = 0; i < 16; i++) tbl[i] = 0;
            q.delete();
        end else begin
            acc = issue_valid && !(m_busy != 0 && m_rem > 1);
            if (m_busy != 0) begin
                if (m_rem == 1) m_busy = 0;
                else m_rem = m_rem - 1;
            end
            if (acc) begin
                c = tbl[issue_opcode];
                m_busy = 1;
                m_rem = lat_of(c);
                m_slow = c % 2;
                q.push_back(int'(issue_opcode));
            end
            if (cfg_we) tbl[cfg_addr] = int'(cfg_class);
        end
    end

    // compare between edges
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R8 wb_valid", int'(wb_valid), int'(m_busy != 0 && m_rem == 1));
            chk("R7 fetch_stall", int'(fetch_stall), int'(m_busy != 0 && m_rem > 1));
            chk("R4 R6 ex_en", int'(ex_en),
                int'(!(m_busy != 0 && m_slow != 0 && m_rem == 2)));
            if (!ex_en) gate_cnt++;
            if (wb_valid) begin
                wb_seen++;
                last_wb_cyc = cyc;
                if (q.size() == 0) chk("R8 extra write-back", 1, 0);
                else chk("R8 wb order", int'(wb_opcode), q.pop_front());
            end
        end
    end

    task automatic cfg(int a, int c);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = OW'(a); cfg_class = 2'(c);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic run_one(int opc, int exp_l, int exp_g, string tag);
        int c0, w0, g0;
        repeat (FPN + 3) @(posedge clk);
        #1;
        c0 = cyc; w0 = wb_seen; g0 = gate_cnt;
        issue_valid = 1'b1; issue_opcode = OW'(opc);
        @(posedge clk); #1;
        issue_valid = 1'b0;
        repeat (FPN + 3) @(posedge clk);
        #1;
        chk({tag, " latency"}, last_wb_cyc - c0, exp_l);
        chk({tag, " wb count"}, wb_seen - w0, 1);
        chk({tag, " R10 gated cycles"}, gate_cnt - g0, exp_g);
    endtask

    task automatic run_stream();
        int p [9] = '{1, 2, 3, 4, 3, 1, 4, 4, 2};
        int sum = 0, c0, w0, i;
        bit st;
        foreach (p[k]) sum += (p[k] == 1) ? 2 : (p[k] == 2) ? FPN :
                              (p[k] == 3) ? FPN + 1 : 1;
        repeat (FPN + 3) @(posedge clk);
        #1;
        c0 = cyc; w0 = wb_seen; i = 0;
        issue_valid = 1'b1; issue_opcode = OW'(p[0]);
        while (i < 9) begin
            @(negedge clk);
            st = fetch_stall;
            issue_opcode = st ? OW'(JUNK) : OW'(p[i]);
            @(posedge clk); #1;
            if (!st) i++;
        end
        issue_valid = 1'b0;
        repeat (FPN + 3) @(posedge clk);
        #1;
        chk("R9 stream total cycles", last_wb_cyc - c0, sum);
        chk("R8 R7 stream wb count", wb_seen - w0, 9);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset wb_valid", int'(wb_valid), 0);
        chk("R1 reset fetch_stall", int'(fetch_stall), 0);
        chk("R1 reset ex_en", int'(ex_en), 1);
        @(posedge clk); #1;
        rst = 1'b0;
        run_one(5, 1, 0, "R1 reset class");
        cfg(1, 1);
        cfg(2, 2);
        cfg(3, 3);
        cfg(4, 0);
        cfg(JUNK, 3);
        run_one(4, 1, 0, "R3 fast int");
        run_one(1, 2, 1, "R4 slow int");
        run_one(2, FPN, 0, "R5 fast fp");
        run_one(3, FPN + 1, 1, "R6 slow fp");
        run_stream();
        cfg(1, 2);
        run_one(1, FPN, 0, "R2 rewritten entry");
        done = 1;
        chk("R8 nothing left pending", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule